// File: doc/BRIEF.md
# Receive packet length and address filter

This block sits between a byte-wide demodulated receive stream and a receive FIFO. A start strobe marks the beginning of each packet. After that strobe the block works out how many payload bytes belong to the packet. In fixed-length format that count is a configured 7-bit value. In variable-length format the count is taken from the first received byte. The block then screens the packet on two grounds: an in-band length that exceeds the configured maximum, and a node address that fails the selected comparison. Either failure discards the packet.

Accepted bytes are passed to the FIFO as write strobes with data. A discard is reported as a one-cycle flush pulse, which tells the FIFO to drop anything already written for the packet. The end of an accepted packet is reported as a one-cycle completion pulse, which starts CRC evaluation downstream. An address-match pulse marks the write of an accepted address byte. The configuration inputs are expected to stay constant while a packet is being received.

Top module: `rx_pkt_filter`

## Requirements
- R1: While reset is high, and in the first cycle after it, fifo_wr_o, flush_o, pkt_done_o and addr_irq_o are all 0.
- R2: With cfg_var_len_i=0, the first cfg_len_i bytes after the start strobe are written to the FIFO in order. pkt_done_o pulses in the same cycle as the write of the last of them. If cfg_len_i is 0, pkt_done_o pulses one cycle after the start strobe and nothing is written.
- R3: With cfg_var_len_i=1, the first byte after the start strobe is a length L. That byte is never written. The next L bytes are written, and pkt_done_o pulses with the last write. If L is 0, pkt_done_o pulses one cycle after the length byte.
- R4: With cfg_var_len_i=1, if the length byte, read as an unsigned 8-bit value, is greater than cfg_len_i, flush_o pulses one cycle after it. In that case no byte of the packet is written and no pkt_done_o is given.
- R5: When cfg_addr_mode_i is not 00, the address byte is the first byte after the length byte in variable format, and the very first byte in fixed format. With mode 00 every counted byte is written as data and addr_irq_o stays 0.
- R6: Mode 01 accepts the address byte only when it equals cfg_node_i. On a rejected address, flush_o pulses one cycle after the address byte. The address byte and the rest of the packet are then not written, and no pkt_done_o is given.
- R7: Mode 10 accepts an address byte equal to cfg_node_i or to 0x00.
- R8: Mode 11 accepts an address byte equal to cfg_node_i, to 0x00 or to 0xFF.
- R9: An accepted address byte is written to the FIFO, and addr_irq_o pulses in the same cycle as that write.
- R10: A start strobe that arrives while a packet is in progress causes a flush_o pulse one cycle later, and reception restarts from the first byte. A byte presented in the same cycle as a start strobe is ignored.
- R11: Bytes that arrive when no packet is in progress, or after a packet has completed or been discarded, are not written and cause no pulse.
- R12: Every output is registered. The write for a byte presented at clock edge n is visible after edge n and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_var_len_i | input | 1 | 1: length taken from the first byte; 0: fixed length |
| cfg_len_i | input | LEN_W | Fixed payload length, or maximum permitted in-band length |
| cfg_node_i | input | DATA_W | Node address of this receiver |
| cfg_addr_mode_i | input | 2 | Address comparison: 00 off, 01 exact, 10 node or 0x00, 11 node, 0x00 or 0xFF |
| sop_i | input | 1 | Start pattern detected strobe |
| byte_vld_i | input | 1 | Received byte valid |
| byte_i | input | DATA_W | Received byte |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | DATA_W | FIFO write data |
| flush_o | output | 1 | Discard pulse: drop the current packet from the FIFO |
| pkt_done_o | output | 1 | Packet complete pulse for CRC evaluation |
| addr_irq_o | output | 1 | Address match pulse |

## Verification
The hardest situation to reach from the ports is a restart: a new start strobe that lands part-way through an accepted packet, after some bytes have already been written, and that arrives together with a valid byte. The bench drives exactly this. It starts a variable-length packet, lets three bytes be written, then raises the start strobe and byte-valid in the same cycle. A shorter second packet follows. The bench checks for one flush pulse, for no stray write from the collided byte, and for a clean completion of the second packet. The length boundaries are handled separately by table vectors: an in-band length equal to the maximum, a length of 128 against a maximum of 127, and zero lengths in both formats.

// File: rtl/rx_pkt_filter_pkg.sv
package rx_pkt_filter_pkg;

  typedef enum logic [1:0] {
    ADDR_OFF    = 2'b00,
    ADDR_EXACT  = 2'b01,
    ADDR_BC0    = 2'b10,
    ADDR_BC0_FF = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEN,
    ST_ADDR,
    ST_PAY
  } rx_state_e;

endpackage

// File: rtl/rx_pf_addr_cmp.sv
module rx_pf_addr_cmp
  import rx_pkt_filter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] node_i,
  input  logic [DATA_W-1:0] addr_i,
  output logic              ok_o
);
  localparam logic [DATA_W-1:0] BC_ZERO = '0;
  localparam logic [DATA_W-1:0] BC_ONES = {DATA_W{1'b1}};

  logic hit_node, hit_zero, hit_ones;

  assign hit_node = (addr_i == node_i);
  assign hit_zero = (addr_i == BC_ZERO);
  assign hit_ones = (addr_i == BC_ONES);

  always_comb begin
    unique case (addr_mode_e'(mode_i))
      ADDR_OFF:    ok_o = 1'b1;
      ADDR_EXACT:  ok_o = hit_node;
      ADDR_BC0:    ok_o = hit_node | hit_zero;
      ADDR_BC0_FF: ok_o = hit_node | hit_zero | hit_ones;
      default:     ok_o = 1'b0;
    endcase
  end

  always_comb begin
    if (mode_i == 2'b01) begin
      AST_EXACT_ONLY_NODE: assert (ok_o == hit_node); // R6
    end
  end
endmodule

// File: rtl/rx_pf_len_ctr.sv
module rx_pf_len_ctr #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (load_i) begin
      rem <= load_val_i;
    end else if (dec_i) begin
      rem <= rem - ONE;
    end
  end

  assign last_o = (rem == ONE);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i) |-> (rem != '0)); // R2
endmodule

// File: rtl/rx_pkt_filter.sv
module rx_pkt_filter
  import rx_pkt_filter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_var_len_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [DATA_W-1:0] cfg_node_i,
  input  logic [1:0]        cfg_addr_mode_i,
  input  logic              sop_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              flush_o,
  output logic              pkt_done_o,
  output logic              addr_irq_o
);
  rx_state_e        state;
  logic             addr_ok, ctr_last, ctr_load, ctr_dec;
  logic [LEN_W-1:0] ctr_val;
  logic             len_too_big, len_zero, addr_on, fixed_empty;
  rx_state_e        first_data_st;

  assign len_too_big   = (byte_i > DATA_W'(cfg_len_i));
  assign len_zero      = (byte_i == '0);
  assign addr_on       = (cfg_addr_mode_i != ADDR_OFF);
  assign fixed_empty   = (cfg_len_i == '0);
  assign first_data_st = addr_on ? ST_ADDR : ST_PAY;

  rx_pf_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .mode_i (cfg_addr_mode_i),
    .node_i (cfg_node_i),
    .addr_i (byte_i),
    .ok_o   (addr_ok)
  );

  always_comb begin
    ctr_load = 1'b0;
    ctr_val  = cfg_len_i;
    ctr_dec  = 1'b0;
    if (sop_i) begin
      ctr_load = !cfg_var_len_i;
    end else if (byte_vld_i) begin
      unique case (state)
        ST_LEN: begin
          if (!len_too_big && !len_zero) begin
            ctr_load = 1'b1;
            ctr_val  = byte_i[LEN_W-1:0];
          end
        end
        ST_ADDR: ctr_dec = addr_ok;
        ST_PAY:  ctr_dec = 1'b1;
        default: ;
      endcase
    end
  end

  rx_pf_len_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (ctr_load),
    .load_val_i (ctr_val),
    .dec_i      (ctr_dec),
    .last_o     (ctr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      fifo_wr_o   <= 1'b0;
      fifo_data_o <= '0;
      flush_o     <= 1'b0;
      pkt_done_o  <= 1'b0;
      addr_irq_o  <= 1'b0;
    end else begin
      fifo_wr_o  <= 1'b0;
      flush_o    <= 1'b0;
      pkt_done_o <= 1'b0;
      addr_irq_o <= 1'b0;
      if (sop_i) begin
        flush_o <= (state != ST_IDLE);
        if (cfg_var_len_i) begin
          state <= ST_LEN;
        end else if (fixed_empty) begin
          pkt_done_o <= 1'b1;
          state      <= ST_IDLE;
        end else begin
          state <= first_data_st;
        end
      end else if (byte_vld_i) begin
        unique case (state)
          ST_LEN: begin
            if (len_too_big) begin
              flush_o <= 1'b1;
              state   <= ST_IDLE;
            end else if (len_zero) begin
              pkt_done_o <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              state <= first_data_st;
            end
          end
          ST_ADDR: begin
            if (addr_ok) begin
              fifo_wr_o   <= 1'b1;
              fifo_data_o <= byte_i;
              addr_irq_o  <= 1'b1;
              if (ctr_last) begin
                pkt_done_o <= 1'b1;
                state      <= ST_IDLE;
              end else begin
                state <= ST_PAY;
              end
            end else begin
              flush_o <= 1'b1;
              state   <= ST_IDLE;
            end
          end
          ST_PAY: begin
            fifo_wr_o   <= 1'b1;
            fifo_data_o <= byte_i;
            if (ctr_last) begin
              pkt_done_o <= 1'b1;
              state      <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    addr_irq_o |-> fifo_wr_o); // R9
  AST_LEN_NOT_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LEN && byte_vld_i && !sop_i) |=> !fifo_wr_o); // R3
  AST_LEN_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LEN && byte_vld_i && !sop_i && len_too_big) |=> (flush_o && !pkt_done_o)); // R4
  AST_ADDR_REJECT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && byte_vld_i && !sop_i && !addr_ok) |=> (flush_o && !fifo_wr_o)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !sop_i) |=> (!fifo_wr_o && !flush_o && !pkt_done_o)); // R11
  AST_NO_WRITE_AND_FLUSH: assert property (@(posedge clk) disable iff (rst)
    !(fifo_wr_o && flush_o)); // R10
endmodule

// File: tb/rx_pkt_filter_test.sv
module rx_pkt_filter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_var = 1'b0;
  logic [6:0] cfg_len = '0;
  logic [7:0] cfg_node = '0;
  logic [1:0] cfg_mode = '0;
  logic       sop = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] din = '0;
  logic       fifo_wr, flush, done, irq;
  logic [7:0] fifo_data;

  int errors = 0;
  int checks = 0;
  int wcnt = 0, fcnt = 0, dcnt = 0, icnt = 0;
  logic done_with_wr = 1'b0;
  logic irq_with_wr = 1'b0;
  logic [7:0] wlog [256];

  always #5 clk = ~clk;

  rx_pkt_filter uut (
    .clk(clk), .rst(rst), .cfg_var_len_i(cfg_var), .cfg_len_i(cfg_len),
    .cfg_node_i(cfg_node), .cfg_addr_mode_i(cfg_mode), .sop_i(sop),
    .byte_vld_i(vld), .byte_i(din), .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data),
    .flush_o(flush), .pkt_done_o(done), .addr_irq_o(irq)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_wr) begin
        wlog[wcnt[7:0]] = fifo_data;
        wcnt = wcnt + 1;
      end
      if (flush) fcnt = fcnt + 1;
      if (done) begin
        dcnt = dcnt + 1;
        done_with_wr = fifo_wr;
      end
      if (irq) begin
        icnt = icnt + 1;
        irq_with_wr = fifo_wr;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks = checks + 1;
    if (got != exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clear_counts();
    wcnt = 0; fcnt = 0; dcnt = 0; icnt = 0;
    done_with_wr = 1'b0; irq_with_wr = 1'b0;
  endtask

  task automatic start_pkt(input logic with_byte, input logic [7:0] b);
    @(negedge clk);
    sop = 1'b1; vld = with_byte; din = b;
    @(negedge clk);
    sop = 1'b0; vld = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    vld = 1'b1; din = b;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] pay(input int k, input logic [7:0] a);
    return (k == 0) ? a : 8'(8'hA0 + k);
  endfunction

  function automatic logic match(input logic [1:0] m, input logic [7:0] n, input logic [7:0] a);
    case (m)
      2'b00:   return 1'b1;
      2'b01:   return a == n;
      2'b10:   return (a == n) || (a == 8'h00);
      default: return (a == n) || (a == 8'h00) || (a == 8'hFF);
    endcase
  endfunction

  // {var, mode, cfg_len, node, length byte, address byte}
  localparam int NV = 16;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 2'd0, 7'd4,   8'h5A, 8'd0,   8'h11},  // R2 R5 fixed, no filter
    {1'b0, 2'd1, 7'd3,   8'h5A, 8'd0,   8'h5A},  // R5 R6 R9 fixed exact hit
    {1'b0, 2'd1, 7'd3,   8'h5A, 8'd0,   8'h5B},  // R6 fixed exact miss
    {1'b1, 2'd0, 7'd10,  8'h5A, 8'd5,   8'h33},  // R3 variable
    {1'b1, 2'd1, 7'd10,  8'h5A, 8'd10,  8'h5A},  // R3 R4 length equal to max
    {1'b1, 2'd0, 7'd10,  8'h5A, 8'd11,  8'h33},  // R4 length over max
    {1'b1, 2'd2, 7'd8,   8'h5A, 8'd3,   8'h00},  // R7 broadcast zero
    {1'b1, 2'd2, 7'd8,   8'h5A, 8'd3,   8'hFF},  // R7 ones rejected
    {1'b1, 2'd3, 7'd8,   8'h5A, 8'd3,   8'hFF},  // R8 ones accepted
    {1'b1, 2'd3, 7'd8,   8'h5A, 8'd3,   8'h00},  // R8 zero accepted
    {1'b1, 2'd3, 7'd8,   8'h5A, 8'd3,   8'h7E},  // R8 other rejected
    {1'b1, 2'd2, 7'd8,   8'h5A, 8'd3,   8'h5A},  // R7 node accepted
    {1'b0, 2'd0, 7'd0,   8'h5A, 8'd0,   8'h11},  // R2 fixed zero length
    {1'b1, 2'd0, 7'd10,  8'h5A, 8'd0,   8'h11},  // R3 length byte zero
    {1'b1, 2'd0, 7'd127, 8'h5A, 8'd128, 8'h11},  // R4 128 over 127
    {1'b0, 2'd1, 7'd1,   8'h5A, 8'd0,   8'h5A}   // R9 address byte is last
  };

  initial begin
    #2_000_000;
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, with inputs active during reset
    sop = 1'b1; vld = 1'b1; din = 8'h42;
    @(negedge clk);
    chk("R1 wr in reset", int'(fifo_wr), 0);
    chk("R1 pulses in reset", int'(flush | done | irq), 0);
    sop = 1'b0; vld = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", int'({fifo_wr, flush, done, irq}), 0);

    for (int v = 0; v < NV; v++) begin
      logic       vr;
      logic [1:0] md;
      logic [6:0] cl;
      logic [7:0] nd, lb, ab;
      int n, nsend, ew, ef, ed, ei;
      logic len_ok, acc;
      {vr, md, cl, nd, lb, ab} = VEC[v];
      cfg_var = vr; cfg_mode = md; cfg_len = cl; cfg_node = nd;
      settle();
      clear_counts();
      len_ok = !vr || (lb <= {1'b0, cl});
      n = vr ? int'(lb) : int'(cl);
      acc = len_ok && (n == 0 || match(md, nd, ab));
      ew = acc ? n : 0;
      ef = acc ? 0 : 1;
      ed = acc ? 1 : 0;
      ei = (acc && n > 0 && md != 2'b00) ? 1 : 0;
      nsend = len_ok ? n : 3;
      start_pkt(1'b0, 8'h00);
      if (vr) put(lb);
      for (int k = 0; k < nsend; k++) put(pay(k, ab));
      put(8'hEE);  // R11 trailing bytes after the packet
      put(8'hEF);
      settle();
      chk($sformatf("R2/R3/R11 vec%0d writes", v), wcnt, ew);
      chk($sformatf("R4/R6 vec%0d flush", v), fcnt, ef);
      chk($sformatf("R2/R3 vec%0d done", v), dcnt, ed);
      chk($sformatf("R5/R9 vec%0d irq", v), icnt, ei);
      if (ew > 0) begin
        int bad = 0;
        for (int k = 0; k < ew; k++) if (wlog[k] != pay(k, ab)) bad++;
        chk($sformatf("R2/R3 vec%0d data mismatches", v), bad, 0);
        chk($sformatf("R2/R3 vec%0d done with last write", v), int'(done_with_wr), 1);
      end
      if (ei > 0) chk($sformatf("R9 vec%0d irq with write", v), int'(irq_with_wr), 1);
    end

    // R10 restart mid-packet, colliding byte ignored
    cfg_var = 1'b1; cfg_mode = 2'd0; cfg_len = 7'd10;
    settle();
    clear_counts();
    start_pkt(1'b0, 8'h00);
    put(8'd6);
    put(8'h01); put(8'h02); put(8'h03);
    start_pkt(1'b1, 8'h02);
    put(8'd2);
    put(8'h0A); put(8'h0B);
    settle();
    chk("R10 flush on restart", fcnt, 1);
    chk("R10 total writes", wcnt, 5);
    chk("R10 second packet done", dcnt, 1);
    chk("R10 second packet data", int'({wlog[3], wlog[4]}), int'(16'h0A0B));

    // R11 bytes with no packet open
    settle();
    clear_counts();
    put(8'h55); put(8'h66); put(8'h77);
    settle();
    chk("R11 idle bytes ignored", wcnt + fcnt + dcnt + icnt, 0);

    // R12 one-cycle registered latency
    cfg_var = 1'b0; cfg_len = 7'd1;
    settle();
    start_pkt(1'b0, 8'h00);
    vld = 1'b1; din = 8'h9C;
    #1;
    chk("R12 no write before edge", int'(fifo_wr), 0);
    @(negedge clk);
    vld = 1'b0;
    chk("R12 write after edge", int'(fifo_wr), 1);
    chk("R12 data after edge", int'(fifo_data), int'(8'h9C));
    settle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule